// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block moves one byte at a time over a clocked serial link with three signals: a serial clock, a data input and a data output. A host starts a transfer by strobing a byte into the port while it is idle. The port then runs exactly eight clock periods. On every falling clock edge the next outgoing bit, most significant first, appears on the data output. On every rising edge the data input is sampled into the shift register. After the eighth rising edge the port stops on its own, stores the received byte and raises an interrupt request flag. The flag stays set until the host clears it.

The data output is driven at all times by an output latch, so the last bit sent stays on the line between transfers. While idle, the host can set this latch with a release strobe or clear it with a command strobe. The serial clock comes either from an internal divider of the system clock, which drives the clock output pin, or from an external clock input. The external input is resynchronised and its edges are detected on the system clock. In internal mode the clock pin rests at a level chosen by the host.

Top module: `sio3_port`

## Requirements
- R1: After reset, busy and irq are 0, sdo is 1 and rx_data is 0.
- R2: A tx_wr strobe while busy is 0 loads tx_data and sets busy in the next cycle. A tx_wr strobe while busy is 1 changes neither the bits sent nor the bits received.
- R3: In a transfer sdo shows tx_data[7], then bit 6, down to bit 0. Each new bit appears together with a falling edge of the serial clock.
- R4: sdi is sampled on each rising serial clock edge, first sample into bit 7. At the end of the transfer rx_data holds the eight samples.
- R5: In the cycle in which busy falls after the eighth rising edge, irq is 1. irq then stays 1 until an irq_clr strobe, which clears it in the next cycle.
- R6: Between transfers sdo keeps its last value (bit 0 of the previous byte) until a release or command strobe.
- R7: While idle, rel_wr drives sdo to 1 in the next cycle and cmd_wr drives it to 0. When both strobes come together, cmd_wr wins.
- R8: rel_wr and cmd_wr strobes while busy is 1 leave sdo unchanged.
- R9: In internal mode (ext_mode 0), sck_out equals sck_idle_hi while idle. During a transfer it starts high for HALF_DIV cycles and then toggles every HALF_DIV cycles, so the falling edges are 2*HALF_DIV cycles apart.
- R10: In external mode (ext_mode 1), edges of sck_in pass through a two-stage synchroniser and then shift and sample exactly as internal edges do. Eight external periods complete one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects the external serial clock on sck_in |
| sck_idle_hi | input | 1 | Host clock-level latch: idle level of sck_out in internal mode |
| sck_in | input | 1 | External serial clock, idles high |
| sck_out | output | 1 | Serial clock produced in internal mode |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output, driven from the output latch |
| tx_wr | input | 1 | Strobe: load tx_data and start a transfer |
| tx_data | input | 8 | Byte to send |
| rel_wr | input | 1 | Strobe: set the output latch (idle only) |
| cmd_wr | input | 1 | Strobe: clear the output latch (idle only) |
| irq_clr | input | 1 | Strobe: clear the interrupt request flag |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request flag, set at the end of a transfer |
| rx_data | output | 8 | Byte received by the last transfer |

## Verification
The hardest case to reach from the ports is a host strobe (a new byte, a release or a command) that arrives in the middle of a running transfer. It has to land between two clock edges, and what has to be shown is that it has no effect at all. The bench acts as the far end of the link. It watches sck_out for falling edges and fires these strobes right after the fourth edge. It then checks that sdo still shows the current bit and that every later bit sent and received matches the original byte. Random bytes from a fixed seed run in both clock modes, and in external mode the bench generates sck_in itself.

// File: rtl/sio3_pkg.sv
package sio3_pkg;

    localparam int SIO_WIDTH_DEF   = 8;
    localparam int SIO_HALF_DEF    = 4;
    localparam int SIO_SYNC_DEF    = 2;

    // one-cycle serial clock edge events seen on the system clock
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_ev_t;

    localparam sck_ev_t SCK_EV_NONE = '{fall: 1'b0, rise: 1'b0};

    function automatic sck_ev_t pick_events(input logic ext, input sck_ev_t int_ev,
                                            input sck_ev_t ext_ev);
        return ext ? ext_ev : int_ev;
    endfunction

endpackage

// File: rtl/sio3_clkgen.sv
module sio3_clkgen
    import sio3_pkg::*;
#(
    parameter int HALF_DIV = SIO_HALF_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    output logic    lvl_o,
    output sck_ev_t ev_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          wrap;

    assign wrap = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ev_o      = SCK_EV_NONE;
        ev_o.fall = wrap && lvl_q;
        ev_o.rise = wrap && !lvl_q;
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/sio3_extsync.sv
module sio3_extsync
    import sio3_pkg::*;
#(
    parameter int SYNC_STAGES = SIO_SYNC_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    sck_in,
    output sck_ev_t ev_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q[0] <= sck_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q <= cur;
        end
    end

    always_comb begin
        ev_o      = SCK_EV_NONE;
        ev_o.fall = run && prev_q && !cur;
        ev_o.rise = run && !prev_q && cur;
    end

endmodule

// File: rtl/sio3_shifter.sv
module sio3_shifter
    import sio3_pkg::*;
#(
    parameter int WIDTH = SIO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  sck_ev_t          ev,
    input  logic             tx_wr,
    input  logic [WIDTH-1:0] tx_data,
    input  logic             rel_wr,
    input  logic             cmd_wr,
    input  logic             irq_clr,
    input  logic             sdi,
    output logic             busy,
    output logic             irq,
    output logic             sdo,
    output logic [WIDTH-1:0] rx_data
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

    logic [WIDTH-1:0] shreg_q;
    logic [WIDTH-1:0] shreg_nx;
    logic [CW-1:0]    bitcnt_q;

    assign shreg_nx = {shreg_q[WIDTH-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            irq      <= 1'b0;
            sdo      <= 1'b1;
            rx_data  <= '0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else begin
            if (irq_clr) begin
                irq <= 1'b0;
            end
            if (!busy) begin
                if (cmd_wr) begin
                    sdo <= 1'b0;
                end else if (rel_wr) begin
                    sdo <= 1'b1;
                end
                if (tx_wr) begin
                    busy     <= 1'b1;
                    shreg_q  <= tx_data;
                    bitcnt_q <= '0;
                end
            end else begin
                if (ev.fall) begin
                    sdo <= shreg_q[WIDTH-1];
                end
                if (ev.rise) begin
                    shreg_q <= shreg_nx;
                    if (bitcnt_q == LAST_BIT) begin
                        busy    <= 1'b0;
                        irq     <= 1'b1;
                        rx_data <= shreg_nx;
                    end else begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sio3_port.sv
module sio3_port
    import sio3_pkg::*;
#(
    parameter int WIDTH       = SIO_WIDTH_DEF,
    parameter int HALF_DIV    = SIO_HALF_DEF,
    parameter int SYNC_STAGES = SIO_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_mode,
    input  logic             sck_idle_hi,
    input  logic             sck_in,
    output logic             sck_out,
    input  logic             sdi,
    output logic             sdo,
    input  logic             tx_wr,
    input  logic [WIDTH-1:0] tx_data,
    input  logic             rel_wr,
    input  logic             cmd_wr,
    input  logic             irq_clr,
    output logic             busy,
    output logic             irq,
    output logic [WIDTH-1:0] rx_data
);
    sck_ev_t int_ev;
    sck_ev_t ext_ev;
    sck_ev_t sel_ev;
    logic    int_lvl;
    logic    int_run;
    logic    ext_run;

    assign int_run = busy && !ext_mode;
    assign ext_run = busy && ext_mode;

    sio3_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (int_run),
        .lvl_o(int_lvl),
        .ev_o (int_ev)
    );

    sio3_extsync #(.SYNC_STAGES(SYNC_STAGES)) u_extsync (
        .clk   (clk),
        .rst   (rst),
        .run   (ext_run),
        .sck_in(sck_in),
        .ev_o  (ext_ev)
    );

    assign sel_ev  = pick_events(ext_mode, int_ev, ext_ev);
    assign sck_out = int_run ? int_lvl : sck_idle_hi;

    sio3_shifter #(.WIDTH(WIDTH)) u_shifter (
        .clk    (clk),
        .rst    (rst),
        .ev     (sel_ev),
        .tx_wr  (tx_wr),
        .tx_data(tx_data),
        .rel_wr (rel_wr),
        .cmd_wr (cmd_wr),
        .irq_clr(irq_clr),
        .sdi    (sdi),
        .busy   (busy),
        .irq    (irq),
        .sdo    (sdo),
        .rx_data(rx_data)
    );

endmodule

// File: rtl/sio3_port_chk.sv
module sio3_port_chk (
    input logic clk,
    input logic rst,
    input logic tx_wr,
    input logic rel_wr,
    input logic cmd_wr,
    input logic irq_clr,
    input logic busy,
    input logic irq,
    input logic sdo
);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !busy) |=> busy);

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_wr && !cmd_wr && !busy) |=> sdo);

    // R7
    command_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> !sdo);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(rel_wr) && !$past(cmd_wr)) |-> $stable(sdo));

endmodule

bind sio3_port sio3_port_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tx_wr  (tx_wr),
    .rel_wr (rel_wr),
    .cmd_wr (cmd_wr),
    .irq_clr(irq_clr),
    .busy   (busy),
    .irq    (irq),
    .sdo    (sdo)
);

// File: tb/sio3_port_test.sv
module sio3_port_test;
    localparam int HALF = 4;
    localparam int EXT_HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0;
    logic       sck_idle_hi = 1'b1;
    logic       sck_in = 1'b1;
    logic       sck_out;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rel_wr = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       busy;
    logic       irq;
    logic [7:0] rx_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sio3_port #(.WIDTH(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .sck_idle_hi(sck_idle_hi),
        .sck_in(sck_in), .sck_out(sck_out), .sdi(sdi), .sdo(sdo),
        .tx_wr(tx_wr), .tx_data(tx_data), .rel_wr(rel_wr), .cmd_wr(cmd_wr),
        .irq_clr(irq_clr), .busy(busy), .irq(irq), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int i);
        return b[7-i];
    endfunction

    task automatic finish_checks(input logic [7:0] tx, input logic [7:0] rin);
        chk(irq == 1'b1, "R5 irq at end", irq, 1);
        chk(rx_data == rin, "R4 received byte", rx_data, rin);
        chk(sdo == tx[0], "R6 last bit held", sdo, tx[0]);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1 && sdo == tx[0], "R5 R6 hold while idle", {irq, sdo}, {1'b1, tx[0]});
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R5 irq cleared", irq, 0);
    endtask

    task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rin, input bit disturb);
        int falls = 0;
        int guard = 0;
        int last_fall = -1;
        int pending = 0;
        logic prev;
        tx_wr = 1'b1; tx_data = tx;
        @(negedge clk);
        tx_wr = 1'b0; tx_data = ~tx;
        chk(busy == 1'b1, "R2 start", busy, 1);
        chk(sck_out == 1'b1, "R9 clock starts high", sck_out, 1);
        prev = sck_out;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
            tx_wr = 1'b0; rel_wr = 1'b0; cmd_wr = 1'b0;
            if (pending != 0) begin
                chk(sdo == tx[4], "R8 strobe while busy ignored", sdo, tx[4]);
                pending = 0;
            end
            if (prev && !sck_out) begin
                chk(sdo == exp_bit(tx, falls), "R3 bit on falling edge", sdo, exp_bit(tx, falls));
                if (last_fall >= 0)
                    chk(guard - last_fall == 2 * HALF, "R9 clock period", guard - last_fall, 2 * HALF);
                last_fall = guard;
                sdi = exp_bit(rin, falls);
                if (disturb && falls == 3) begin
                    tx_wr = 1'b1; tx_data = 8'h5A;
                    if (tx[4]) cmd_wr = 1'b1; else rel_wr = 1'b1;
                    pending = 1;
                end
                falls++;
            end
            prev = sck_out;
        end
        chk(falls == 8, "R3 eight falling edges", falls, 8);
        finish_checks(tx, rin);
    endtask

    task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rin);
        tx_wr = 1'b1; tx_data = tx;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(busy == 1'b1, "R2 start ext", busy, 1);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            sdi = exp_bit(rin, i);
            repeat (EXT_HALF) @(negedge clk);
            chk(sdo == exp_bit(tx, i), "R10 ext bit out", sdo, exp_bit(tx, i));
            if (i < 7)
                chk(busy == 1'b1, "R10 busy mid transfer", busy, 1);
            sck_in = 1'b1;
            repeat (EXT_HALF) @(negedge clk);
        end
        chk(busy == 1'b0, "R10 ext done", busy, 0);
        finish_checks(tx, rin);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && irq == 1'b0, "R1 busy/irq after reset", {busy, irq}, 0);
        chk(sdo == 1'b1, "R1 sdo after reset", sdo, 1);
        chk(rx_data == 8'h00, "R1 rx after reset", rx_data, 0);

        // R7 idle latch control
        cmd_wr = 1'b1; @(negedge clk); cmd_wr = 1'b0;
        chk(sdo == 1'b0, "R7 command clears", sdo, 0);
        rel_wr = 1'b1; @(negedge clk); rel_wr = 1'b0;
        chk(sdo == 1'b1, "R7 release sets", sdo, 1);
        rel_wr = 1'b1; cmd_wr = 1'b1; @(negedge clk); rel_wr = 1'b0; cmd_wr = 1'b0;
        chk(sdo == 1'b0, "R7 both strobes", sdo, 0);

        // R9 idle level follows host latch
        sck_idle_hi = 1'b0; @(negedge clk);
        chk(sck_out == 1'b0, "R9 idle low", sck_out, 0);
        sck_idle_hi = 1'b1; @(negedge clk);
        chk(sck_out == 1'b1, "R9 idle high", sck_out, 1);

        // directed corner bytes
        xfer_int(8'h80, 8'h01, 1'b0);
        xfer_int(8'hFF, 8'h00, 1'b0);
        xfer_int(8'h00, 8'hFF, 1'b0);
        // R2 R8 strobes mid transfer
        xfer_int(8'hB4, 8'h3C, 1'b1);
        xfer_int(8'h6B, 8'hC5, 1'b1);

        // random internal transfers
        for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = 8'($urandom);
            b = 8'($urandom);
            xfer_int(a, b, k[0]);
        end

        // R10 external clock mode
        ext_mode = 1'b1;
        @(negedge clk);
        xfer_ext(8'hA5, 8'h96);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = 8'($urandom);
            b = 8'($urandom);
            xfer_ext(a, b);
        end
        ext_mode = 1'b0;
        @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule